// File: doc/BRIEF.md
# Leading/Trailing Zero Counter

This block counts consecutive zero bits in a 64-bit operand for an execution pipeline. A direction select chooses whether counting starts at the most significant end (leading) or at the least significant end (trailing). A size select chooses between a full 64-bit doubleword and a 32-bit word. In word mode only the low 32 bits of the operand are examined.

A single datapath serves all four combinations. Trailing counts reuse the leading-zero encoder on a bit-reversed operand. Word mode moves the low word to the top of the encoder input, and the final count is clamped to the active width, so an all-zero operand gives exactly 64 or 32.

The count is registered and returned zero-extended to 64 bits one clock edge after the inputs are presented.

Top module: `zero_count_unit`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) makes `count_o` equal 0 after that edge.
- R2: The result for the inputs sampled at a rising edge appears on `count_o` right after that edge and holds until the next edge.
- R3: Doubleword leading mode (`word_mode_i`=0, `from_lsb_i`=0) returns 63 minus the index of the highest set bit. If bit 63 is set, the result is 0.
- R4: Doubleword trailing mode (`word_mode_i`=0, `from_lsb_i`=1) returns the index of the lowest set bit.
- R5: Word leading mode (`word_mode_i`=1, `from_lsb_i`=0) returns 31 minus the index of the highest set bit within bits 31..0. Bits 63..32 have no effect.
- R6: Word trailing mode (`word_mode_i`=1, `from_lsb_i`=1) returns the index of the lowest set bit within bits 31..0. It returns 32 when bits 31..0 are all zero, whatever bits 63..32 hold.
- R7: An all-zero operand returns 64 in doubleword mode and 32 in word mode, in either direction.
- R8: Bits 63..7 of `count_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Operand to examine |
| from_lsb_i | input | 1 | 0 = count leading zeros, 1 = count trailing zeros |
| word_mode_i | input | 1 | 0 = 64-bit operand, 1 = low 32 bits only |
| count_o | output | 64 | Registered zero count, zero-extended |

## Verification
Two functions can meet in the same cycle: word-mode masking of the upper half, and the saturation of an empty word to 32. They collide when the low word is zero and the upper word carries set bits. The bench provokes this by rotating and shifting random operands through every position in word mode. Each result is compared against a bench model that scans only bits 31..0. If the upper word leaked into the count, the result would be below 32; if the clamp were missing, it would reach 64.

// File: rtl/zc_pkg.sv
// Package: shared constants and types for the zero counter.
// Assumes a power-of-two operand width of at least 4 bits.
package zc_pkg;
    parameter int ZC_DATA_W = 64;

    typedef enum logic {
        DIR_FROM_MSB = 1'b0,
        DIR_FROM_LSB = 1'b1
    } zc_dir_e;
endpackage

// File: rtl/zc_prep.sv
// Operand preparation: turns any of the four modes into a leading-zero
// problem. It reverses the bits for trailing counts and moves the low word
// to the top in word mode. It also reports the saturation limit
// (full width or half width).
// Assumes DATA_W is even.
module zc_prep #(
    parameter int DATA_W = 64,
    localparam int HALF  = DATA_W / 2,
    localparam int CNT_W = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] src,
    input  logic              from_lsb,
    input  logic              word_mode,
    output logic [DATA_W-1:0] vec,
    output logic [CNT_W-1:0]  limit
);
    import zc_pkg::*;

    logic [DATA_W-1:0] rev_full;
    logic [HALF-1:0]   rev_low;
    zc_dir_e           dir;

    assign dir = zc_dir_e'(from_lsb);

    // Bit-reverse the whole operand and the low word.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
        assign rev_full[i] = src[DATA_W-1-i];
    end
    for (genvar j = 0; j < HALF; j++) begin : g_rev_low
        assign rev_low[j] = src[HALF-1-j];
    end

    // Select the encoder input and the saturation limit for the mode.
    always_comb begin
        if (word_mode) begin
            vec   = (dir == DIR_FROM_LSB) ? {rev_low, {HALF{1'b0}}}
                                          : {src[HALF-1:0], {HALF{1'b0}}};
            limit = CNT_W'(HALF);
        end else begin
            vec   = (dir == DIR_FROM_LSB) ? rev_full : src;
            limit = CNT_W'(DATA_W);
        end
    end
endmodule

// File: rtl/zc_lzc.sv
// Leading-zero encoder: the number of zero bits above the highest set bit.
// It returns W when the input is all zero.
// Purely combinational.
module zc_lzc #(
    parameter int W      = 64,
    localparam int CNT_W = $clog2(W) + 1
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);
    // Priority scan: the highest set bit wins because it is visited last.
    always_comb begin
        cnt = CNT_W'(W);
        for (int k = 0; k < W; k++) begin
            if (vec[k]) cnt = CNT_W'(W - 1 - k);
        end
    end
endmodule

// File: rtl/zero_count_unit.sv
// Top: registered leading/trailing zero count over a doubleword or a word.
// Assumes the inputs are stable around the rising edge of clk.
// rst_n is synchronous and active low.
module zero_count_unit #(
    parameter int DATA_W = zc_pkg::ZC_DATA_W,
    localparam int HALF  = DATA_W / 2,
    localparam int CNT_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              from_lsb_i,
    input  logic              word_mode_i,
    output logic [DATA_W-1:0] count_o
);
    logic [DATA_W-1:0] enc_in;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  lz_raw;
    logic [CNT_W-1:0]  lz_sat;
    logic [CNT_W-1:0]  cnt_q;

    zc_prep #(.DATA_W(DATA_W)) u_prep (
        .src       (src_i),
        .from_lsb  (from_lsb_i),
        .word_mode (word_mode_i),
        .vec       (enc_in),
        .limit     (limit)
    );

    zc_lzc #(.W(DATA_W)) u_lzc (
        .vec (enc_in),
        .cnt (lz_raw)
    );

    // Clamp the raw count to the active operand width.
    always_comb begin
        lz_sat = (lz_raw > limit) ? limit : lz_raw;
    end

    // Register the count; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= lz_sat;
    end

    assign count_o = DATA_W'(cnt_q);

    // R1: reset clears the result.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> count_o == '0);

    // R7: a zero operand saturates at the active width.
    assert_zero_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> count_o == ($past(word_mode_i) ? DATA_W'(HALF) : DATA_W'(DATA_W)));

    // R3: doubleword leading count with the top bit set is 0.
    assert_msb_set_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_mode_i && !from_lsb_i && src_i[DATA_W-1]) |=> count_o == '0);

    // R4: trailing count with bit 0 set is 0.
    assert_lsb_set_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (from_lsb_i && src_i[0]) |=> count_o == '0);

    // R5: a word-mode result never exceeds half the width.
    assert_word_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode_i |=> count_o <= DATA_W'(HALF));

    // R2: the result holds while the inputs are unchanged.
    assert_result_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(src_i) && $stable(from_lsb_i) && $stable(word_mode_i) && $past(rst_n))
        |=> $stable(count_o));
endmodule

// File: tb/zero_count_unit_bench.sv
module zero_count_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src_i;
    logic        from_lsb_i;
    logic        word_mode_i;
    logic [63:0] count_o;

    int n_checks = 0;
    int n_fails  = 0;

    zero_count_unit u_zero_count_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .from_lsb_i  (from_lsb_i),
        .word_mode_i (word_mode_i),
        .count_o     (count_o)
    );

    always #5 clk = ~clk;

    // Model of the count, built from the requirements.
    function automatic logic [63:0] model_count(logic [63:0] s, logic lsb, logic w);
        int n = w ? 32 : 64;
        for (int k = 0; k < n; k++) begin
            if (s[lsb ? k : n - 1 - k]) return 64'(k);
        end
        return 64'(n);
    endfunction

    function automatic string req_tag(logic [63:0] s, logic lsb, logic w);
        if (w ? (s[31:0] == 0) : (s == 0)) return "R7";
        if (!w && !lsb) return "R3";
        if (!w && lsb)  return "R4";
        if (w && !lsb)  return "R5";
        return "R6";
    endfunction

    task automatic compare(string tag, logic [63:0] exp);
        n_checks++;
        if (count_o !== exp) begin
            n_fails++;
            $display("FAIL %s: src=%h lsb=%0b word=%0b got=%h exp=%h",
                     tag, src_i, from_lsb_i, word_mode_i, count_o, exp);
        end
        // R8: bits 63..7 are zero.
        n_checks++;
        if (count_o[63:7] !== '0) begin
            n_fails++;
            $display("FAIL R8: upper bits got=%h exp=0", count_o[63:7]);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next
    // rising edge and checked at the falling edge after it (R2).
    task automatic apply(logic [63:0] s, logic lsb, logic w);
        @(negedge clk);
        src_i = s; from_lsb_i = lsb; word_mode_i = w;
        @(negedge clk);
        compare(req_tag(s, lsb, w), model_count(s, lsb, w));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got=timeout exp=finish");
        summary();
        $finish;
    end

    initial begin : stim
        logic [63:0] r;
        void'($urandom(32'h5eed_0c0d));
        rst_n = 1'b0; src_i = '1; from_lsb_i = 1'b0; word_mode_i = 1'b0;
        repeat (2) @(negedge clk);
        compare("R1", 64'd0);
        rst_n = 1'b1;

        // R7: zero operand, all four modes.
        apply(64'd0, 1'b0, 1'b0);
        apply(64'd0, 1'b1, 1'b0);
        apply(64'd0, 1'b0, 1'b1);
        apply(64'd0, 1'b1, 1'b1);
        // R6: empty low word, full upper word.
        apply(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1);
        // R5: upper bits ignored.
        apply(64'hFFFF_FFFF_0000_0001, 1'b0, 1'b1);
        // R3: top bit set.
        apply(64'h8000_0000_0000_0000, 1'b0, 1'b0);
        // R4: only bit 63 set.
        apply(64'h8000_0000_0000_0000, 1'b1, 1'b0);

        // R2: inputs held; the output must stay put.
        apply(64'h0000_0100_0000_0000, 1'b0, 1'b0);
        @(negedge clk);
        compare("R2", 64'd23);

        // Random operands shifted through every position, in all modes.
        for (int j = 0; j < 6; j++) begin
            r = {$urandom, $urandom};
            r[63] = 1'b1;
            for (int i = 0; i < 64; i++) begin
                apply(r, 1'b0, 1'b0);
                apply({r[31:0], r[63:32]}, 1'b0, 1'b1);
                r = {1'b0, r[63:1]};
            end
            r = {$urandom, $urandom};
            r[0] = 1'b1;
            for (int i = 0; i < 64; i++) begin
                apply(r, 1'b1, 1'b0);
                apply(r, 1'b1, 1'b1);
                r = {r[62:0], 1'b0};
            end
        end

        // R1: reset in mid-run with a nonzero operand.
        @(negedge clk);
        src_i = 64'h1; from_lsb_i = 1'b0; word_mode_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        compare("R1", 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R3", 64'd63);

        summary();
        $finish;
    end
endmodule